// File: doc/BRIEF.md
# Masked Majority Coincidence Trigger

This block forms a sector trigger for two detector sectors at once. Each sector supplies a group of OR signals, one per half-chamber, and the group size is a parameter of 13 or 15. All inputs are resynchronised to the 40 MHz machine clock. Each input is then either dropped by a per-input mask or kept. Each kept input is assigned to one of six detector layers, and a sector fires when enough distinct layers show activity. A per-input force word can make chosen inputs compulsory. This raises selectivity for cosmic or calibration running.

The raw OR lines are also re-registered and sent out unchanged, so a time-to-digital converter can record them. The masks, forces, layer assignments and thresholds sit in registers. A plain synchronous write port loads them, standing in for the serial management slave that feeds the block in the system.

Top module: `sct_top`

## Requirements
- R1: The two groups are independent. `or_a` drives only `trig_a` and `or_b` drives only `trig_b`, and each group has its own configuration registers.
- R2: A change on an OR input shows on its trigger after exactly three rising clock edges: two synchroniser stages and one output register.
- R3: An input whose mask bit is 1 counts as inactive. It adds no layer, and with all inputs masked the trigger stays 0.
- R4: An input whose force bit is 1 must be active and unmasked for the trigger to assert. A forced input that is also masked holds the trigger at 0.
- R5: The count is the number of distinct layers, with codes 0 to 5, that hold at least one active unmasked input. Layer codes 6 and 7 add no layer. The trigger is 1 when the count is at least the threshold and the force rule holds.
- R6: A threshold write of 0 stores 1, a write above 6 stores 6, and a write of 1 to 6 stores the value itself. The whole data word is compared, not only its low bits.
- R7: Synchronous reset, active high, sets the following state: all masks and forces to 0, both thresholds to 6, the layer code of input i to i mod 6, and both triggers to 0.
- R8: `rtx_a` and `rtx_b` equal `or_a` and `or_b` one clock later. Masks and forces have no effect on them.
- R9: A write with `cfg_we`=1 takes effect at the next edge. `cfg_addr[7]` selects the group (0 for A, 1 for B). `cfg_addr[6:0]` selects the register: 0x00 is the mask word, 0x01 the force word, 0x02 the threshold, and 0x20+i the layer of input i (data bits [2:0]). Bit i of a mask or force word belongs to input i. Any other offset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz machine clock |
| rst | input | 1 | Synchronous reset, active high |
| or_a | input | NUM_IN | OR lines of sector A |
| or_b | input | NUM_IN | OR lines of sector B |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Group select (top bit) and register offset |
| cfg_wdata | input | DATA_W | Register write data |
| trig_a | output | 1 | Registered trigger of sector A |
| trig_b | output | 1 | Registered trigger of sector B |
| rtx_a | output | NUM_IN | Registered copy of `or_a` |
| rtx_b | output | NUM_IN | Registered copy of `or_b` |

## Verification
Masking and forcing act on the same input in the same cycle when one channel has both bits set. The bench provokes this by forcing and masking one input while it is driven high. The trigger must stay low even though the threshold of 1 is met. The bench also drives a masked channel while it checks the retransmit copy, and expects the masked value to pass through one cycle later while the trigger ignores it.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int LAYER_W  = 3;
  localparam int N_LAYERS = 6;
  localparam int THR_W    = 3;
  localparam int THR_MIN  = 1;
  localparam int THR_MAX  = 6;
  localparam int CNT_W    = 3;

  localparam int OFS_MASK  = 'h00;
  localparam int OFS_FORCE = 'h01;
  localparam int OFS_THR   = 'h02;
  localparam int OFS_LAYER = 'h20;

  typedef logic [LAYER_W-1:0] layer_t;
  typedef logic [THR_W-1:0]   thr_t;
endpackage

// File: rtl/sct_sync.sv
module sct_sync #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;

  AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stage2_q == $past(stage1_q)); // R2
endmodule

// File: rtl/sct_cfg.sv
module sct_cfg
  import sct_pkg::*;
#(
  parameter int NUM_IN = 13,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic                       sel,
  input  logic [OFS_W-1:0]           ofs,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_IN-1:0]          mask,
  output logic [NUM_IN-1:0]          force_in,
  output thr_t                       thr,
  output logic [NUM_IN*LAYER_W-1:0]  layer_flat
);
  logic [NUM_IN-1:0] mask_q;
  logic [NUM_IN-1:0] force_q;
  thr_t              thr_q;
  thr_t              thr_clamped;
  layer_t            layer_q [NUM_IN];
  logic              wr_hit;

  assign wr_hit = we && sel;

  always_comb begin
    if (wdata == '0)
      thr_clamped = thr_t'(THR_MIN);
    else if (wdata > DATA_W'(THR_MAX))
      thr_clamped = thr_t'(THR_MAX);
    else
      thr_clamped = wdata[THR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      force_q <= '0;
      thr_q   <= thr_t'(THR_MAX);
    end else if (wr_hit) begin
      if (ofs == OFS_W'(OFS_MASK))  mask_q  <= wdata[NUM_IN-1:0];
      if (ofs == OFS_W'(OFS_FORCE)) force_q <= wdata[NUM_IN-1:0];
      if (ofs == OFS_W'(OFS_THR))   thr_q   <= thr_clamped;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IN; i++)
        layer_q[i] <= layer_t'(i % N_LAYERS);
    end else if (wr_hit) begin
      for (int i = 0; i < NUM_IN; i++)
        if (ofs == OFS_W'(OFS_LAYER + i))
          layer_q[i] <= wdata[LAYER_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_flat
    assign layer_flat[i*LAYER_W +: LAYER_W] = layer_q[i];
  end

  assign mask     = mask_q;
  assign force_in = force_q;
  assign thr      = thr_q;

  AST_THR_RANGE: assert property (@(posedge clk) disable iff (rst)
    thr_q >= thr_t'(THR_MIN) && thr_q <= thr_t'(THR_MAX)); // R6
  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mask_q == '0 && force_q == '0 && thr_q == thr_t'(THR_MAX)); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_hit)) |-> $stable(mask_q) && $stable(force_q) && $stable(thr_q)); // R9
endmodule

// File: rtl/sct_majority.sv
module sct_majority
  import sct_pkg::*;
#(
  parameter int NUM_IN = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_IN-1:0]          ors,
  input  logic [NUM_IN-1:0]          mask,
  input  logic [NUM_IN-1:0]          force_in,
  input  thr_t                       thr,
  input  logic [NUM_IN*LAYER_W-1:0]  layer_flat,
  output logic                       trig
);
  logic [NUM_IN-1:0]   active;
  logic [N_LAYERS-1:0] layer_hit;
  logic [CNT_W-1:0]    layer_cnt;
  logic                force_ok;
  logic                trig_d;
  logic                trig_q;

  assign active = ors & ~mask;

  always_comb begin
    layer_hit = '0;
    for (int i = 0; i < NUM_IN; i++)
      for (int l = 0; l < N_LAYERS; l++)
        if (active[i] && layer_flat[i*LAYER_W +: LAYER_W] == layer_t'(l))
          layer_hit[l] = 1'b1;
  end

  always_comb begin
    layer_cnt = '0;
    for (int l = 0; l < N_LAYERS; l++)
      layer_cnt = layer_cnt + CNT_W'(layer_hit[l]);
  end

  assign force_ok = (force_in & ~active) == '0;
  assign trig_d   = force_ok && (layer_cnt >= CNT_W'(thr));

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig_d;
  end

  assign trig = trig_q;

  AST_FORCE_GATE: assert property (@(posedge clk) disable iff (rst)
    trig_q |-> $past((force_in & ~(ors & ~mask)) == '0)); // R4
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (&mask) |=> !trig_q); // R3
  AST_NO_ACTIVITY: assert property (@(posedge clk) disable iff (rst)
    (ors == '0) |=> !trig_q); // R5
endmodule

// File: rtl/sct_top.sv
module sct_top
  import sct_pkg::*;
#(
  parameter int NUM_IN = 13,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] or_a,
  input  logic [NUM_IN-1:0] or_b,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              trig_a,
  output logic              trig_b,
  output logic [NUM_IN-1:0] rtx_a,
  output logic [NUM_IN-1:0] rtx_b
);
  localparam int OFS_W = ADDR_W - 1;
  localparam int N_GRP = 2;

  logic [NUM_IN-1:0] raw [N_GRP];
  logic [N_GRP-1:0]  trig;
  logic [NUM_IN-1:0] rtx_a_q;
  logic [NUM_IN-1:0] rtx_b_q;

  assign raw[0] = or_a;
  assign raw[1] = or_b;

  for (genvar g = 0; g < N_GRP; g++) begin : g_sec
    logic [NUM_IN-1:0]         synced;
    logic [NUM_IN-1:0]         grp_mask;
    logic [NUM_IN-1:0]         grp_force;
    thr_t                      grp_thr;
    logic [NUM_IN*LAYER_W-1:0] grp_layer;

    sct_sync #(.W(NUM_IN)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[g]),
      .dout (synced)
    );

    sct_cfg #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_cfg (
      .clk        (clk),
      .rst        (rst),
      .we         (cfg_we),
      .sel        (cfg_addr[ADDR_W-1] == 1'(g)),
      .ofs        (cfg_addr[OFS_W-1:0]),
      .wdata      (cfg_wdata),
      .mask       (grp_mask),
      .force_in   (grp_force),
      .thr        (grp_thr),
      .layer_flat (grp_layer)
    );

    sct_majority #(.NUM_IN(NUM_IN)) u_maj (
      .clk        (clk),
      .rst        (rst),
      .ors        (synced),
      .mask       (grp_mask),
      .force_in   (grp_force),
      .thr        (grp_thr),
      .layer_flat (grp_layer),
      .trig       (trig[g])
    );
  end

  always_ff @(posedge clk) begin
    rtx_a_q <= or_a;
    rtx_b_q <= or_b;
  end

  assign trig_a = trig[0];
  assign trig_b = trig[1];
  assign rtx_a  = rtx_a_q;
  assign rtx_b  = rtx_b_q;

  AST_RTX_COPY: assert property (@(posedge clk) disable iff (rst)
    rtx_a_q == $past(or_a) && rtx_b_q == $past(or_b)); // R8
  AST_IDLE_GROUP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (or_b == '0 && $past(or_b) == '0 && $past(or_b, 2) == '0 && !$past(rst, 3)) |=> !trig_b); // R1
endmodule

// File: tb/sct_top_test.sv
module sct_top_test;
  localparam int CLK_PERIOD = 25;
  localparam int N  = 13;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  or_a = '0;
  logic [N-1:0]  or_b = '0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          trig_a, trig_b;
  logic [N-1:0]  rtx_a, rtx_b;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  sct_top #(.NUM_IN(N), .DATA_W(16), .ADDR_W(8)) uut (
    .clk(clk), .rst(rst), .or_a(or_a), .or_b(or_b),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .trig_a(trig_a), .trig_b(trig_b), .rtx_a(rtx_a), .rtx_b(rtx_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // default layer of input i is i mod 6
  localparam logic [15:0] V_MASK  [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                           16'h0004, 16'h0004, 16'h0000, 16'h0000, 16'h0010,
                                           16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [15:0] V_FORCE [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                           16'h0000, 16'h0000, 16'h0010, 16'h0010, 16'h0010,
                                           16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [15:0] V_THR   [NV] = '{16'd6, 16'd6, 16'd1, 16'd3, 16'd3,
                                           16'd3, 16'd2, 16'd1, 16'd1, 16'd1,
                                           16'd0, 16'd9, 16'd9, 16'd7};
  localparam logic [15:0] V_IN    [NV] = '{16'h003F, 16'h0041, 16'h0041, 16'h0007, 16'h0003,
                                           16'h0007, 16'h0107, 16'h0001, 16'h0011, 16'h0011,
                                           16'h1000, 16'h0FC0, 16'h07C0, 16'h001F};
  localparam logic        V_EXP   [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
                                           1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                           1'b1, 1'b1, 1'b0, 1'b0};

  function automatic string tag_of(input int v);
    case (v)
      5, 6:        return "R3";
      7, 8, 9:     return "R4";
      10, 11, 12, 13: return "R6";
      default:     return "R5";
    endcase
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic grp, input logic [6:0] ofs, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = {grp, ofs}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_v(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    chk("R7 trig_a in reset", trig_a, 1'b0);
    chk("R7 trig_b in reset", trig_b, 1'b0);
    rst = 1'b0;
    wait_n(3);
    chk("R7 trig_a after reset", trig_a, 1'b0);

    // R2 latency with default threshold 6 and default layers (R7)
    or_a = 13'h003F;
    wait_n(2);
    chk("R2 not yet after two edges", trig_a, 1'b0);
    wait_n(1);
    chk("R2/R7 asserted after three edges", trig_a, 1'b1);
    or_a = '0;
    wait_n(2);
    chk("R2 still high two edges after drop", trig_a, 1'b1);
    wait_n(1);
    chk("R2 low three edges after drop", trig_a, 1'b0);

    // table walk on group A
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, 7'h00, V_MASK[v]);
      wr(1'b0, 7'h01, V_FORCE[v]);
      wr(1'b0, 7'h02, V_THR[v]);
      or_a = V_IN[v][N-1:0];
      wait_n(3);
      chk($sformatf("%s vector %0d", tag_of(v), v), trig_a, V_EXP[v]);
      chk($sformatf("R1 group B quiet at vector %0d", v), trig_b, 1'b0);
    end

    // R5 layer remap
    wr(1'b0, 7'h00, 16'h0000);
    wr(1'b0, 7'h01, 16'h0000);
    wr(1'b0, 7'h02, 16'd2);
    wr(1'b0, 7'h21, 16'd0);
    or_a = 13'h0003;
    wait_n(3);
    chk("R5 two inputs on one layer", trig_a, 1'b0);
    wr(1'b0, 7'h02, 16'd1);
    wr(1'b0, 7'h21, 16'd7);
    or_a = 13'h0006;
    wait_n(3);
    chk("R5 code 7 plus layer 2", trig_a, 1'b1);
    or_a = 13'h0002;
    wait_n(3);
    chk("R5 code 7 adds no layer", trig_a, 1'b0);

    // R1/R9 group separation
    wr(1'b0, 7'h02, 16'd6);
    wr(1'b1, 7'h02, 16'd1);
    or_a = 13'h0001;
    or_b = 13'h0001;
    wait_n(3);
    chk("R1 group A keeps its threshold", trig_a, 1'b0);
    chk("R9 group B threshold written", trig_b, 1'b1);

    // R9 unknown offset ignored
    wr(1'b0, 7'h02, 16'd1);
    wait_n(3);
    chk("R9 baseline before unknown write", trig_a, 1'b1);
    wr(1'b0, 7'h05, 16'hFFFF);
    wr(1'b0, 7'h40, 16'hFFFF);
    wait_n(3);
    chk("R9 unknown offsets ignored", trig_a, 1'b1);

    // R8 retransmit untouched by masks
    wr(1'b0, 7'h00, 16'h1FFF);
    wr(1'b1, 7'h00, 16'h1FFF);
    or_a = 13'h0ABC;
    or_b = 13'h1555;
    wait_n(1);
    chk_v("R8 rtx_a copy", rtx_a, 13'h0ABC);
    chk_v("R8 rtx_b copy", rtx_b, 13'h1555);
    wait_n(3);
    chk("R3 all masked", trig_a, 1'b0);

    // R7 reset restores defaults
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    or_a = 13'h003F;
    or_b = 13'h0001;
    wait_n(3);
    chk("R7 masks cleared, threshold 6, layers restored", trig_a, 1'b1);
    chk("R7 group B threshold back to 6", trig_b, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule